// File: doc/BRIEF.md
# Sequenced Late-Window Watchdog

This block supervises a processor that must prove it is alive by writing two key bytes in order to a service register: first 0x55, then 0xAA. A free-running cycle counter measures the timeout period, which is set on a configuration input. When the counter reaches the end of the period without a completed sequence, the block forces a reset. The block can also run in windowed mode. In that mode any service write that arrives before the final quarter of the period counts as a fault. Code that services too often is caught as surely as code that never services.

A write with the wrong key also forces a reset, and so does a single-cycle strobe from the processor that reports an illegal instruction. Every cause drives the same active-low reset output. That output can be tied to peripheral reset inputs as well as to the processor. It stays low for a fixed number of cycles. A cause register records which faults fired. It keeps its value through that self-generated reset and is cleared only by the block's own reset input.

Top module: `wdog_seq_top`

## Requirements
- R1: After `rst_n` is sampled low, `rst_out_n` is 1, `cause` is 0 and the period counter restarts from zero.
- R2: In non-windowed mode (`win_mode`=0), a write of 0x55 followed by a write of 0xAA restarts the period counter at any count. Cycles without a write may fall between the two writes. No reset follows.
- R3: If no sequence completes within `period` cycles of a counter restart, `rst_out_n` falls exactly `period` cycles after the restart, and `cause` becomes 4'b0001 (bit 0 = timeout).
- R4: A write other than 0x55 while no sequence is in progress, or a write other than 0xAA directly after an accepted 0x55, forces a reset with cause bit 2 (bad key).
- R5: In windowed mode (`win_mode`=1), any write made while the count is below `period - period/4` forces a reset with cause bit 1 (early). With `period`=16, count 11 is early and count 12 is not.
- R6: In windowed mode, a sequence whose two writes both fall at counts at or above `period - period/4` is accepted and restarts the counter.
- R7: A high `illegal_op` in a cycle forces a reset with cause bit 3. Faults raised in the same cycle are recorded together: a bad key plus an illegal strobe gives 4'b1100.
- R8: `rst_out_n` stays low for exactly `PULSE_LEN` (16) cycles. After that the period counter starts again from zero.
- R9: While `rst_out_n` is low, service writes and illegal strobes are ignored: the pulse length does not change and `cause` holds. `cause` keeps its value after the pulse until the next fault or until `rst_n`.
- R10: A sequence whose 0xAA write lands on the last count of the period (`period`-1) is accepted, and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block, clears the cause register |
| wr_en | input | 1 | Service register write strobe, one cycle per write |
| wr_data | input | 8 | Byte written to the service register |
| illegal_op | input | 1 | Illegal-instruction strobe from the processor |
| win_mode | input | 1 | 1 selects windowed service, 0 accepts service at any count |
| period | input | PER_W | Timeout period in cycles, at least 4, changed only under reset |
| rst_out_n | output | 1 | Active-low reset request to the processor and peripherals |
| cause | output | 4 | Faults of the last reset: bit0 timeout, bit1 early, bit2 bad key, bit3 illegal op |

## Verification
The embedded assertions watch properties on every cycle:
- `cause` is frozen and nonzero whenever the reset output is low.
- The counter is at zero throughout the pulse and right after an expiry.
- In windowed mode no sequence is accepted outside the window.
- The sequence tracker arms only on a 0x55 write.

Only the bench's scenarios can show the rest:
- the exact 16-cycle pulse length and the exact cycle on which a timeout fires;
- the early/late boundary at count 11 versus count 12;
- acceptance of a sequence finishing on the final count;
- the combined cause code for coincident faults.

A bench reference model also follows long random runs of mixed keys, strobes and modes.

// File: rtl/wdog_pkg.sv
// Package: shared constants and types for the sequenced watchdog.
// Assumes: cause bit positions are fixed and visible at the top port.
package wdog_pkg;
    localparam logic [7:0] SVC_KEY_FIRST  = 8'h55;
    localparam logic [7:0] SVC_KEY_SECOND = 8'hAA;

    localparam int CAUSE_W    = 4;
    localparam int CI_TIMEOUT = 0;
    localparam int CI_EARLY   = 1;
    localparam int CI_BADKEY  = 2;
    localparam int CI_ILLEGAL = 3;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;
endpackage

// File: rtl/wdog_win_timer.sv
// Module: period counter with window and expiry flags.
// Counts up from zero each cycle unless cleared. The window opens at
// period - period/4. Expiry is flagged on the last count, period-1.
// Assumes: period >= 4 and constant outside reset.
module wdog_win_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PER_W-1:0] period,
    output logic [PER_W-1:0] count,
    output logic             window_open,
    output logic             expire
);
    localparam logic [PER_W-1:0] ONE = {{(PER_W-1){1'b0}}, 1'b1};

    logic [PER_W-1:0] window_start;

    // Window boundary and end-of-period decode.
    always_comb begin
        window_start = period - (period >> 2);
        window_open  = (count >= window_start);
        expire       = (count == period - ONE);
    end

    // Counter: restart on clear, otherwise advance one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/wdog_svc_seq.sv
// Module: service key sequence tracker.
// Classifies each write as accepted, early or bad, and tracks whether a
// first key has been taken. Early takes priority over a key check.
// Assumes: clear is raised by the top on any fault or while held.
module wdog_svc_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       win_mode,
    input  logic       window_open,
    output logic       svc_ok,
    output logic       early,
    output logic       bad_key
);
    seq_state_t state;
    logic       first_ok;

    // Classify the current write against mode, window and tracker state.
    always_comb begin
        early    = wr_en && win_mode && !window_open;
        first_ok = (state == SEQ_IDLE) && (wr_data == SVC_KEY_FIRST);
        svc_ok   = wr_en && !early && (state == SEQ_ARMED)
                   && (wr_data == SVC_KEY_SECOND);
        bad_key  = wr_en && !early && !svc_ok && !first_ok;
    end

    // Tracker: arm on a good first key, drop on completion or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else if (clear || svc_ok) begin
            state <= SEQ_IDLE;
        end else if (wr_en && first_ok && !early) begin
            state <= SEQ_ARMED;
        end
    end

    // R6
    win_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_ok && win_mode) |-> window_open);

    // R2
    arm_on_first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_ARMED && $past(state) == SEQ_IDLE)
        |-> $past(wr_en && wr_data == SVC_KEY_FIRST));
endmodule

// File: rtl/wdog_rst_pulse.sv
// Module: reset pulse stretcher and cause register.
// Any fault while idle loads the pulse length and captures the fault bits.
// While the pulse runs, faults are ignored and the cause holds.
// Assumes: fault_in bits follow the wdog_pkg cause positions.
module wdog_rst_pulse
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] fault_in,
    output logic               hold,
    output logic               rst_out_n,
    output logic [CAUSE_W-1:0] cause
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN);

    logic [PW-1:0] remain;

    // Pulse is active while cycles remain.
    always_comb begin
        hold      = (remain != '0);
        rst_out_n = !hold;
    end

    // Count the pulse down, or start one and capture the fault bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            cause  <= '0;
        end else if (hold) begin
            remain <= remain - PW'(1);
        end else if (|fault_in) begin
            remain <= LOAD;
            cause  <= fault_in;
        end
    end

    // R9
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(cause));

    // R8
    cause_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> (cause != '0));
endmodule

// File: rtl/wdog_seq_top.sv
// Module: sequenced late-window watchdog, top level.
// Joins the period timer, key tracker and reset pulse. Fault sources are
// timeout (expiry without completion), early write, bad key and illegal op.
// Assumes: period >= 4, constant outside reset; one write per strobe cycle.
module wdog_seq_top
    import wdog_pkg::*;
#(
    parameter int PER_W     = 16,
    parameter int PULSE_LEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               illegal_op,
    input  logic               win_mode,
    input  logic [PER_W-1:0]   period,
    output logic               rst_out_n,
    output logic [CAUSE_W-1:0] cause
);
    logic [PER_W-1:0]   count;
    logic               window_open, expire;
    logic               svc_ok, early, bad_key;
    logic               hold;
    logic [CAUSE_W-1:0] faults;
    logic               any_fault, seq_clear, tmr_clear;

    // Gather fault sources and the clear terms for timer and tracker.
    always_comb begin
        faults              = '0;
        faults[CI_TIMEOUT]  = expire && !svc_ok;
        faults[CI_EARLY]    = early;
        faults[CI_BADKEY]   = bad_key;
        faults[CI_ILLEGAL]  = illegal_op;
        any_fault           = |faults;
        seq_clear           = hold || any_fault;
        tmr_clear           = seq_clear || svc_ok;
    end

    wdog_win_timer #(.PER_W(PER_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (tmr_clear),
        .period      (period),
        .count       (count),
        .window_open (window_open),
        .expire      (expire)
    );

    wdog_svc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (seq_clear),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .win_mode    (win_mode),
        .window_open (window_open),
        .svc_ok      (svc_ok),
        .early       (early),
        .bad_key     (bad_key)
    );

    wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_in  (faults),
        .hold      (hold),
        .rst_out_n (rst_out_n),
        .cause     (cause)
    );

    // R8
    held_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |-> (count == '0));

    // R3
    expiry_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == '0));

    // R3
    fault_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out_n && any_fault) |=> !rst_out_n);
endmodule

// File: tb/wdog_seq_top_bench.sv
// Bench: directed corner cases plus seeded random stimulus. Outputs are
// compared each cycle with a reference model written from the requirements.
module wdog_seq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PER_W      = 16;
    localparam int PULSE      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = 8'h00;
    logic             illegal_op = 1'b0;
    logic             win_mode = 1'b0;
    logic [PER_W-1:0] period = 16;
    logic             rst_out_n;
    logic [3:0]       cause;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_en = 1'b0;
    string tag = "R1";

    // Reference model state.
    int       m_cnt = 0;
    int       m_pulse = 0;
    bit       m_armed = 1'b0;
    logic [3:0] m_cause = 4'h0;
    int       m_ws;
    bit       m_open, m_e, m_ok, m_b, m_t;
    logic [3:0] m_f;

    wdog_seq_top #(.PER_W(PER_W), .PULSE_LEN(PULSE)) u_wdog_seq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .illegal_op (illegal_op),
        .win_mode   (win_mode),
        .period     (period),
        .rst_out_n  (rst_out_n),
        .cause      (cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model step, one per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pulse = 0; m_armed = 0; m_cause = 4'h0;
        end else if (m_pulse != 0) begin
            m_pulse = m_pulse - 1; m_cnt = 0; m_armed = 0;
        end else begin
            m_ws   = int'(period) - int'(period) / 4;
            m_open = (m_cnt >= m_ws);
            m_e    = wr_en && win_mode && !m_open;
            m_ok   = wr_en && !m_e && m_armed && (wr_data == 8'hAA);
            m_b    = wr_en && !m_e && !m_ok && !(!m_armed && wr_data == 8'h55);
            m_t    = (m_cnt == int'(period) - 1) && !m_ok;
            m_f    = {illegal_op, m_b, m_e, m_t};
            if (m_f != 4'h0) begin
                m_pulse = PULSE; m_cause = m_f; m_cnt = 0; m_armed = 0;
            end else if (m_ok) begin
                m_cnt = 0; m_armed = 0;
            end else begin
                m_cnt = m_cnt + 1;
                if (wr_en && wr_data == 8'h55) m_armed = 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check(rst_out_n == (m_pulse == 0), tag, "rst_out_n vs model",
                  int'(rst_out_n), int'(m_pulse == 0));
            check(cause == m_cause, tag, "cause vs model", int'(cause), int'(m_cause));
        end
    end

    task automatic do_reset(input int per, input bit win);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; illegal_op = 1'b0;
        period = PER_W'(per); win_mode = win;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write1(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        while (m_cnt != v || m_pulse != 0) @(negedge clk);
    endtask

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual 0 expected 1 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int m;
        int r;
        int junk;
        junk = $urandom(32'h00C0FFEE);

        // R1: reset state.
        do_reset(16, 0);
        cmp_en = 1'b1;
        check(rst_out_n == 1'b1, "R1", "rst_out_n after reset", int'(rst_out_n), 1);
        check(cause == 4'h0, "R1", "cause after reset", int'(cause), 0);

        // R3: timeout fires exactly period cycles after restart.
        tag = "R3";
        n = 0;
        while (rst_out_n) begin @(negedge clk); n++; end
        check(n == 16, "R3", "cycles to timeout", n, 16);
        check(cause == 4'h1, "R3", "timeout cause", int'(cause), 1);

        // R8: pulse length, then the counter restarts from zero.
        tag = "R8";
        m = 0;
        while (!rst_out_n) begin @(negedge clk); m++; end
        check(m == PULSE, "R8", "pulse length", m, PULSE);
        n = 0;
        while (rst_out_n) begin @(negedge clk); n++; end
        check(n == 16, "R8", "cycles to timeout after pulse", n, 16);

        // R9: writes and strobes during the pulse are ignored.
        tag = "R9";
        wr_en = 1'b1; wr_data = 8'h12; illegal_op = 1'b1;
        m = 0;
        while (!rst_out_n) begin @(negedge clk); m++; end
        wr_en = 1'b0; illegal_op = 1'b0;
        check(m == PULSE, "R9", "pulse length with stimulus", m, PULSE);
        check(cause == 4'h1, "R9", "cause held after pulse", int'(cause), 1);
        repeat (3) @(negedge clk);
        check(cause == 4'h1, "R9", "cause kept while running", int'(cause), 1);
        do_reset(16, 0);
        check(cause == 4'h0, "R9", "cause cleared by rst_n", int'(cause), 0);

        // R2: non-windowed service at arbitrary counts.
        tag = "R2";
        for (int i = 0; i < 10; i++) begin
            repeat (5) @(negedge clk);
            write1(8'h55);
            repeat (2) @(negedge clk);
            write1(8'hAA);
        end
        check(rst_out_n == 1'b1, "R2", "no reset when serviced", int'(rst_out_n), 1);
        check(cause == 4'h0, "R2", "no cause when serviced", int'(cause), 0);

        // R4: bad first key, and a repeated first key.
        tag = "R4";
        do_reset(16, 0);
        @(negedge clk);
        write1(8'h33);
        check(cause == 4'h4, "R4", "bad first key cause", int'(cause), 4);
        check(rst_out_n == 1'b0, "R4", "bad first key reset", int'(rst_out_n), 0);
        do_reset(16, 0);
        write1(8'h55);
        write1(8'h55);
        check(cause == 4'h4, "R4", "bad second key cause", int'(cause), 4);

        // R5: early writes, including the last count before the window.
        tag = "R5";
        do_reset(16, 1);
        wait_cnt(3);
        write1(8'h55);
        check(cause == 4'h2, "R5", "early write cause", int'(cause), 2);
        do_reset(16, 1);
        wait_cnt(11);
        write1(8'h55);
        check(cause == 4'h2, "R5", "write at count 11 is early", int'(cause), 2);

        // R6: sequence inside the window is accepted, repeatedly.
        tag = "R6";
        do_reset(16, 1);
        for (int i = 0; i < 4; i++) begin
            wait_cnt(12);
            write1(8'h55);
            write1(8'hAA);
        end
        check(rst_out_n == 1'b1, "R6", "window service accepted", int'(rst_out_n), 1);
        check(cause == 4'h0, "R6", "no cause after window service", int'(cause), 0);

        // R10: second key on the last count of the period.
        tag = "R10";
        do_reset(16, 1);
        wait_cnt(14);
        write1(8'h55);
        write1(8'hAA);
        repeat (3) @(negedge clk);
        check(rst_out_n == 1'b1, "R10", "service on last count", int'(rst_out_n), 1);

        // R7: illegal strobe alone, then together with a bad key.
        tag = "R7";
        do_reset(16, 0);
        repeat (5) @(negedge clk);
        illegal_op = 1'b1;
        @(negedge clk);
        illegal_op = 1'b0;
        check(cause == 4'h8, "R7", "illegal op cause", int'(cause), 8);
        do_reset(16, 0);
        repeat (2) @(negedge clk);
        illegal_op = 1'b1;
        write1(8'h77);
        illegal_op = 1'b0;
        check(cause == 4'hC, "R7", "coincident faults cause", int'(cause), 12);

        // Random segments against the model (R3 R4 R5 R7 R8 R9).
        tag = "random R3 R4 R5 R7 R8 R9";
        for (int seg = 0; seg < 4; seg++) begin
            do_reset((seg % 2 == 0) ? 12 : 20, seg[0]);
            for (int c = 0; c < 1000; c++) begin
                r = int'($urandom % 100);
                wr_en = (r < 15);
                r = int'($urandom % 8);
                wr_data = (r < 3) ? 8'h55 : (r < 6) ? 8'hAA : 8'($urandom);
                illegal_op = (($urandom % 400) == 0);
                @(negedge clk);
            end
            wr_en = 1'b0; illegal_op = 1'b0;
        end

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule